// File: doc/BRIEF.md
# Self-Ranging Sample Clock Prescaler with Frame-Driven Standby

This block runs on a master clock that may be any one of seven supported rates: 256, 512, 1536, 1544, 2048, 2560 or 4096 kHz. From that clock it produces a 256 kHz internal tick and an 8 kHz sample strobe. The sample strobe is locked to the external frame sync. The block does not need to be told the master clock rate. It counts master-clock cycles between rising edges of the frame sync, sorts that count into one of the supported rates, and adopts the rate only when two frames in a row agree. The tick comes from a fractional accumulator that adds the tick count per frame on every cycle and wraps at the measured period. The accumulator is cleared on each frame-sync rising edge. Every frame therefore holds exactly 32 ticks, including the 193-cycle frame of the 1544 kHz rate.

The block also decides when the downstream serial port may drive its data line. A power-up input forces the block off. An automatic standby starts when no frame-sync rising edge arrives within one frame period plus a small slack. After either kind of sleep, the block grants output permission only once two whole frames have passed after frame sync returns.

The control is a four-state machine:
- OFF: held while the power-up input is low.
- STANDBY: powered and waiting for a frame sync.
- WAKE: frame sync present, counting the holdoff frames.
- RUN: output permitted.

The transitions are:
- power-down: any state goes to OFF when the power-up input is low.
- power-up: OFF goes to STANDBY.
- sync-seen: STANDBY goes to WAKE on a rising edge of the frame sync.
- holdoff-done: WAKE goes to RUN on the second further rising edge.
- sync-lost: WAKE or RUN goes to STANDBY on a timeout.

Top module: `clk_prescaler`

## Requirements
- R1: After reset, with the power-up input low: standby=1, tx_en=0, ratio_ok=0, rate_code=0, and tick and sample_stb are both 0.
- R2: One cycle after the power-up input is seen low, standby=1, tx_en=0 and ratio_ok=0. The detected rate is forgotten.
- R3: A cycles-per-frame count maps to rate_code as follows:
  - 31..33 gives 1.
  - 63..65 gives 2.
  - 191..192 gives 3.
  - 193..194 gives 4.
  - 255..257 gives 5.
  - 319..321 gives 6.
  - 511..513 gives 7.
  - Any other count gives 0.
  ratio_ok is 1 exactly when the committed code is nonzero.
- R4: A rate is committed only when two consecutive measured frames give the same code. After waking, the first measured frame alone leaves ratio_ok at 0.
- R5: A single frame whose code differs from the frame before it changes neither rate_code nor ratio_ok.
- R6: Two consecutive frames with out-of-table counts clear ratio_ok and rate_code to 0. While ratio_ok is 0, neither tick nor sample_stb pulses.
- R7: While locked and running at a steady rate, exactly 32 tick pulses fall between consecutive sample_stb pulses, at every supported rate.
- R8: While locked and awake, sample_stb pulses for one cycle once per frame-sync rising edge, in the cycle after that edge.
- R9: If no frame-sync rising edge arrives for more than the locked period plus 2 cycles, the block enters standby. When unlocked, the limit is MAX_CNT cycles. Entering standby gives standby=1, tx_en=0 and ratio_ok=0. It never happens within the locked period plus 1 cycle.
- R10: Leaving standby, tx_en stays 0 through the first two frame-sync rising edges. It rises in the cycle after the third rising edge, which marks two whole frames after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, one of the seven supported rates |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to mclk |
| pwr_up | input | 1 | High to power the block, low to force it off |
| tick | output | 1 | One-cycle pulse at 32 per frame (256 kHz) |
| sample_stb | output | 1 | One-cycle pulse per frame (8 kHz sample strobe) |
| ratio_ok | output | 1 | A supported rate is committed |
| rate_code | output | 3 | Committed rate code, 0 when none |
| standby | output | 1 | Block is off or in standby |
| tx_en | output | 1 | Serial output may leave high impedance |

## Verification
The assertions assume that the frame sync is already synchronous to the master clock. They also assume that every high pulse of the frame sync lasts at least one cycle and is followed by a low interval, so that a rising edge can be detected cleanly. The pairing of rate and alignment is likewise taken as given: at the two slowest rates, the master clock edges are assumed to line up with the frame sync. The stimulus meets these assumptions by driving the frame sync only at the falling clock edge. Each frame is a two-cycle high pulse followed by a low interval, and the whole frame is a whole number of master-clock cycles. Frames that are deliberately out of table or early only ever shorten the frame; they never stretch it past the timeout, except in the one test that targets standby.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    typedef enum logic [1:0] {
        PS_OFF,
        PS_STANDBY,
        PS_WAKE,
        PS_RUN
    } pwr_state_t;

    typedef logic [2:0] rate_code_t;

    localparam rate_code_t RATE_NONE  = 3'd0;
    localparam rate_code_t RATE_256K  = 3'd1;
    localparam rate_code_t RATE_512K  = 3'd2;
    localparam rate_code_t RATE_1536K = 3'd3;
    localparam rate_code_t RATE_1544K = 3'd4;
    localparam rate_code_t RATE_2048K = 3'd5;
    localparam rate_code_t RATE_2560K = 3'd6;
    localparam rate_code_t RATE_4096K = 3'd7;

    // true when n lies within one count of nominal c
    function automatic logic near(input int n, input int c);
        return (n + 1 >= c) && (n <= c + 1);
    endfunction

    // 192 and 193 are one count apart, so each gets one-sided tolerance
    function automatic rate_code_t classify(input int n);
        rate_code_t code;
        if (near(n, 32))                  code = RATE_256K;
        else if (near(n, 64))             code = RATE_512K;
        else if (n == 191 || n == 192)    code = RATE_1536K;
        else if (n == 193 || n == 194)    code = RATE_1544K;
        else if (near(n, 256))            code = RATE_2048K;
        else if (near(n, 320))            code = RATE_2560K;
        else if (near(n, 512))            code = RATE_4096K;
        else                              code = RATE_NONE;
        return code;
    endfunction

endpackage

// File: rtl/frame_meter.sv
module frame_meter #(
    parameter int CNT_W   = 10,
    parameter int MAX_CNT = 600,
    parameter int SLACK   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             clr,
    input  logic             locked,
    input  logic [CNT_W-1:0] lock_period,
    output logic             fs_rise,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_CNT + 1);

    logic             fsync_q;
    logic             started;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   limit;

    assign fs_rise  = fsync & ~fsync_q;
    assign meas_vld = fs_rise & started & ~clr;
    assign meas_cnt = cnt;

    always_comb begin
        if (locked) limit = {1'b0, lock_period} + (CNT_W+1)'(SLACK);
        else        limit = (CNT_W+1)'(MAX_CNT);
    end

    assign timeout = ({1'b0, cnt} > limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
            started <= 1'b0;
            cnt     <= '0;
        end else begin
            fsync_q <= fsync;
            if (fs_rise) begin
                started <= 1'b1;
                cnt     <= CNT_W'(1);
            end else begin
                if (clr) started <= 1'b0;
                if (cnt != SAT) cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ratio_lock.sv
module ratio_lock
    import prescaler_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             ratio_ok,
    output rate_code_t       rate_code,
    output logic [CNT_W-1:0] period
);
    rate_code_t cls;
    rate_code_t prev_code;
    logic       have_prev;

    assign cls = classify(int'(meas_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code <= RATE_NONE;
            have_prev <= 1'b0;
            rate_code <= RATE_NONE;
            ratio_ok  <= 1'b0;
            period    <= '0;
        end else if (clr) begin
            prev_code <= RATE_NONE;
            have_prev <= 1'b0;
            rate_code <= RATE_NONE;
            ratio_ok  <= 1'b0;
        end else if (meas_vld) begin
            prev_code <= cls;
            have_prev <= 1'b1;
            if (have_prev && cls == prev_code) begin
                rate_code <= cls;
                ratio_ok  <= (cls != RATE_NONE);
                period    <= meas_cnt;
            end
        end
    end

    // R3: a valid flag always carries a real rate
    p_ok_has_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok |-> rate_code != RATE_NONE);

    // R4: the committed rate only moves on a measurement or a clear
    p_code_moves_on_meas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_code) |-> $past(meas_vld || clr));

endmodule

// File: rtl/tick_synth.sv
module tick_synth #(
    parameter int CNT_W = 10,
    parameter int TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             align,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    localparam int ACC_W = CNT_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    assign sum = (align ? '0 : acc) + ACC_W'(TICKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (!en) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (sum >= {1'b0, period}) begin
            acc  <= sum - {1'b0, period};
            tick <= 1'b1;
        end else begin
            acc  <= sum;
            tick <= 1'b0;
        end
    end

    // R6: no tick comes out of a disabled generator
    p_tick_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(en));

endmodule

// File: rtl/power_fsm.sv
module power_fsm
    import prescaler_pkg::*;
#(
    parameter int WAKE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic fs_rise,
    input  logic timeout,
    output logic standby,
    output logic active,
    output logic tx_en
);
    localparam int WC_W = $clog2(WAKE_FRAMES + 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WAKE_FRAMES - 1);

    pwr_state_t state, state_nx;
    logic [WC_W-1:0] wcnt;

    always_comb begin
        state_nx = state;
        if (!pwr_up) begin
            state_nx = PS_OFF;                                   // power-down
        end else begin
            unique case (state)
                PS_OFF:     state_nx = PS_STANDBY;               // power-up
                PS_STANDBY: if (fs_rise) state_nx = PS_WAKE;     // sync-seen
                PS_WAKE: begin
                    if (timeout)                          state_nx = PS_STANDBY; // sync-lost
                    else if (fs_rise && wcnt == WC_LAST)  state_nx = PS_RUN;     // holdoff-done
                end
                PS_RUN:     if (timeout) state_nx = PS_STANDBY;  // sync-lost
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_OFF;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != PS_WAKE)                 wcnt <= '0;
            else if (state == PS_WAKE && fs_rise)    wcnt <= wcnt + 1'b1;
        end
    end

    always_comb begin
        standby = 1'b0;
        active  = 1'b0;
        tx_en   = 1'b0;
        unique case (state)
            PS_OFF, PS_STANDBY: standby = 1'b1;
            PS_WAKE:            active  = 1'b1;
            PS_RUN: begin
                active = 1'b1;
                tx_en  = 1'b1;
            end
        endcase
    end

    // R2: a low power-up input forces the block off on the next cycle
    p_down_forces_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> standby && !tx_en);

    // R10: output permission only ever starts on a frame-sync edge
    p_tx_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(fs_rise));

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
    import prescaler_pkg::*;
#(
    parameter int MAX_CNT     = 600,
    parameter int SLACK       = 2,
    parameter int TICKS       = 32,
    parameter int WAKE_FRAMES = 2
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic       pwr_up,
    output logic       tick,
    output logic       sample_stb,
    output logic       ratio_ok,
    output logic [2:0] rate_code,
    output logic       standby,
    output logic       tx_en
);
    localparam int CNT_W = $clog2(MAX_CNT + 2);

    logic             fs_rise;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    logic             timeout;
    logic [CNT_W-1:0] period;
    logic             active;
    rate_code_t       code_w;

    frame_meter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .SLACK(SLACK)) meter_i (
        .clk(mclk), .rst_n(rst_n), .fsync(fsync), .clr(standby),
        .locked(ratio_ok), .lock_period(period),
        .fs_rise(fs_rise), .meas_vld(meas_vld), .meas_cnt(meas_cnt),
        .timeout(timeout)
    );

    ratio_lock #(.CNT_W(CNT_W)) lock_i (
        .clk(mclk), .rst_n(rst_n), .clr(standby),
        .meas_vld(meas_vld), .meas_cnt(meas_cnt),
        .ratio_ok(ratio_ok), .rate_code(code_w), .period(period)
    );

    tick_synth #(.CNT_W(CNT_W), .TICKS(TICKS)) ticker_i (
        .clk(mclk), .rst_n(rst_n), .en(ratio_ok & active), .align(fs_rise),
        .period(period), .tick(tick)
    );

    power_fsm #(.WAKE_FRAMES(WAKE_FRAMES)) fsm_i (
        .clk(mclk), .rst_n(rst_n), .pwr_up(pwr_up), .fs_rise(fs_rise),
        .timeout(timeout), .standby(standby), .active(active), .tx_en(tx_en)
    );

    assign rate_code = code_w;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) sample_stb <= 1'b0;
        else        sample_stb <= fs_rise & ratio_ok & active;
    end

    // R8: a strobe is only issued by a locked block
    p_stb_needs_lock_r8: assert property (@(posedge mclk) disable iff (!rst_n)
        sample_stb |-> $past(ratio_ok));

    // R9: standby and output permission never overlap
    p_standby_blocks_tx_r9: assert property (@(posedge mclk) disable iff (!rst_n)
        standby |-> !tx_en);

endmodule

// File: tb/clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module clk_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       pwr_up = 1'b0;
    logic       tick, sample_stb, ratio_ok, standby, tx_en;
    logic [2:0] rate_code;

    int total = 0;
    int bad = 0;
    int tick_total = 0;
    int stb_total = 0;
    int win = 0;
    bit seen = 0;
    bit done = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    clk_prescaler dut_i (
        .mclk(clk), .rst_n(rst_n), .fsync(fsync), .pwr_up(pwr_up),
        .tick(tick), .sample_stb(sample_stb), .ratio_ok(ratio_ok),
        .rate_code(rate_code), .standby(standby), .tx_en(tx_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: samples 2 ns after each rising edge, pops one expectation per window
    always @(posedge clk) begin
        #2;
        if (standby) seen = 0;
        if (sample_stb) begin
            stb_total++;
            if (seen && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                chk(win == e, "R7 ticks per frame", win, e);
            end
            seen = 1;
            win = tick ? 1 : 0;
        end else if (tick) begin
            win++;
        end
        if (tick) tick_total++;
    end

    task automatic frame(input int p);
        fsync = 1'b1;
        repeat (2) @(negedge clk);
        fsync = 1'b0;
        repeat (p - 2) @(negedge clk);
    endtask

    task automatic power_cycle();
        pwr_up = 1'b0;
        repeat (3) @(negedge clk);
        chk(standby == 1'b1, "R2 standby", standby, 1);
        chk(tx_en == 1'b0, "R2 tx_en", tx_en, 0);
        chk(ratio_ok == 1'b0, "R2 ratio_ok", ratio_ok, 0);
        pwr_up = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // driver: wake at period p, expect code, then queue nsb window expectations
    task automatic wake_run(input int p, input int code, input int nsb);
        int s0, t0;
        power_cycle();
        frame(p);
        frame(p);
        chk(tx_en == 1'b0, "R10 holdoff", tx_en, 0);
        chk(ratio_ok == 1'b0, "R4 single frame", ratio_ok, 0);
        frame(p);
        chk(tx_en == 1'b1, "R10 release", tx_en, 1);
        chk(ratio_ok == (code != 0), "R3 ratio_ok", ratio_ok, int'(code != 0));
        chk(rate_code == 3'(code), "R3 rate_code", rate_code, code);
        if (code != 0) begin
            for (int i = 0; i < nsb; i++) exp_q.push_back(32);
        end
        s0 = stb_total;
        t0 = tick_total;
        repeat (nsb + 1) frame(p);
        if (code != 0) begin
            chk(stb_total - s0 == nsb + 1, "R8 strobes", stb_total - s0, nsb + 1);
        end else begin
            chk(tick_total == t0, "R6 no ticks", tick_total - t0, 0);
            chk(stb_total == s0, "R6 no strobes", stb_total - s0, 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(standby == 1'b1, "R1 standby", standby, 1);
        chk(tx_en == 1'b0, "R1 tx_en", tx_en, 0);
        chk(ratio_ok == 1'b0, "R1 ratio_ok", ratio_ok, 0);
        chk(rate_code == 3'd0, "R1 rate_code", rate_code, 0);
        chk(tick == 1'b0 && sample_stb == 1'b0, "R1 pulses", int'(tick | sample_stb), 0);

        // every supported rate, plus tolerance edges (R3, R7)
        wake_run(32, 1, 2);
        wake_run(64, 2, 2);
        wake_run(192, 3, 2);
        wake_run(193, 4, 3);
        wake_run(256, 5, 2);
        wake_run(320, 6, 2);
        wake_run(512, 7, 2);
        wake_run(65, 2, 1);
        wake_run(191, 3, 1);
        wake_run(194, 4, 1);
        wake_run(100, 0, 2);

        // R9 automatic standby, then R10 holdoff after waking
        wake_run(64, 2, 1);
        @(negedge clk);
        chk(standby == 1'b0, "R9 not early", standby, 0);
        repeat (40) @(negedge clk);
        chk(standby == 1'b1, "R9 standby", standby, 1);
        chk(tx_en == 1'b0, "R9 tx_en", tx_en, 0);
        chk(ratio_ok == 1'b0, "R9 ratio_ok", ratio_ok, 0);
        frame(64);
        frame(64);
        chk(tx_en == 1'b0, "R10 holdoff after standby", tx_en, 0);
        frame(64);
        chk(tx_en == 1'b1, "R10 release after standby", tx_en, 1);

        // R5 one odd frame does not move a committed rate
        wake_run(512, 7, 0);
        frame(320);
        frame(512);
        chk(rate_code == 3'd7 && ratio_ok, "R5 after odd frame", rate_code, 7);
        frame(512);
        frame(512);
        chk(rate_code == 3'd7 && ratio_ok, "R5 settled", rate_code, 7);

        // R6 two out-of-table frames clear the rate and stop the pulses
        wake_run(64, 2, 0);
        frame(40);
        frame(40);
        chk(ratio_ok == 1'b1, "R5 first bad frame", ratio_ok, 1);
        frame(64);
        chk(ratio_ok == 1'b0, "R6 cleared", ratio_ok, 0);
        chk(rate_code == 3'd0, "R6 code cleared", rate_code, 0);
        begin
            int t0, s0;
            t0 = tick_total;
            s0 = stb_total;
            frame(64);
            chk(tick_total == t0, "R6 ticks stop", tick_total - t0, 0);
            chk(stb_total == s0, "R6 strobes stop", stb_total - s0, 0);
        end

        chk(exp_q.size() == 0, "R7 all windows seen", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule